// File: doc/BRIEF.md
# Four-Word Burst Handshake Controller

This block negotiates burst transfers on an external memory bus for cache line fills of four 32-bit words. When a requester starts a bus cycle, the controller pulses the address strobe. If burst mode is enabled and the cycle is marked as burst-eligible, it raises a burst request alongside that strobe. The memory side answers with a burst acknowledge on the first word. If the acknowledge is present, the controller runs four word transfers, each closed by a ready pulse. If it is absent, the cycle ends after a single word.

For every beat the controller drives the two word-select address bits. The word order is interleaved: the start word XOR the beat number. A hyperpage (EDO) burst path is also provided. In that path the controller does not take the word bits from the requester. It fetches the line from word 00 upward and does not wait for an acknowledge. Every received word goes back to the requester in bus order with its word index, and the final word carries a last marker. A beat whose ready never arrives within a parameterized number of cycles ends the transfer with a bus-error pulse.

Top module: `burst_handshake_ctrl`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `busy`, `busAs`, `busBurstReq`, `busHyper`, `rspValid` and `rspErr` are all low.
- R2: A `reqValid` seen at a clock edge while `busy` is low produces a `busAs` pulse exactly one cycle long in the following cycle. A `reqValid` seen while `busy` is high is ignored: it produces no `busAs` and does not change the running word sequence.
- R3: `busBurstReq` is high in the `busAs` cycle exactly when `cfgBurstEn` and `reqBurstOk` were both 1 at the accepting edge. It is low in every other cycle.
- R4: `busBurstAck` is sampled only at the edge where `busReady` closes the first word. If `busBurstReq` was raised for the cycle and the acknowledge is 1 there, four words are transferred. Otherwise exactly one word is transferred, and that word carries `rspLast`.
- R5: During beat k (k = 0..3) of a non-hyperpage cycle, `busWord` equals the start word XOR k. A start of 00 gives 00,01,10,11. A start of 01 gives 01,00,11,10. A start of 10 gives 10,11,00,01. A start of 11 gives 11,10,01,00. `busWord` holds steady while a beat waits for ready.
- R6: One cycle after each edge at which `busReady` is accepted, `rspValid` is high for one cycle with `rspData` equal to the `busData` sampled at that edge and `rspIdx` equal to the `busWord` of that beat. `rspLast` is set only on the final word of the cycle.
- R7: Hyperpage burst applies when `cfgHyperEn`, `cfgBurstEn` and `reqBurstOk` are all 1 at acceptance. In that case `busHyper` is high for the whole transfer and four words are always transferred, regardless of `busBurstAck`. `busWord` runs 00,01,10,11 and ignores `reqWord`.
- R8: With `cfgHyperEn` = 1 but `cfgBurstEn` = 0, the cycle is an ordinary single-word transfer: `busHyper` and `busBurstReq` stay low and `busWord` equals `reqWord`.
- R9: Each beat allows `WAIT_LIMIT` cycles, counted from the beat's first cycle. A ready in the last allowed cycle is accepted without error. If no ready arrives in those cycles, `rspErr` pulses for one cycle in the next cycle, no `rspValid` is produced for that beat, and the transfer ends.
- R10: `busy` is high from the cycle after acceptance through the cycle holding the final ready or the timeout. It is low in the cycle that carries the final `rspValid` or the `rspErr`, and a new request can be accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester starts a bus cycle (taken when idle) |
| reqWord | input | IDX_W | Word address bits 3:2 of the request |
| reqBurstOk | input | 1 | This cycle is allowed to burst |
| cfgBurstEn | input | 1 | Burst mode enable |
| cfgHyperEn | input | 1 | Hyperpage (EDO) enable |
| busy | output | 1 | Transfer in progress |
| busAs | output | 1 | Address strobe, one pulse per bus cycle |
| busBurstReq | output | 1 | Burst request, raised with the strobe |
| busHyper | output | 1 | Hyperpage burst in progress |
| busWord | output | IDX_W | Word address bits 3:2 of the current beat |
| busBurstAck | input | 1 | Burst acknowledge from memory |
| busReady | input | 1 | Word completed by memory |
| busData | input | DATA_W | Read data from memory |
| rspValid | output | 1 | One word delivered to the requester |
| rspData | output | DATA_W | Delivered word |
| rspIdx | output | IDX_W | Word index of the delivered word |
| rspLast | output | 1 | Final word of the bus cycle |
| rspErr | output | 1 | Beat timed out; transfer aborted |

## Verification
A ready and the wait-state limit can fall on the same cycle: the last allowed wait cycle of a beat is also the cycle in which the timeout would fire. The bench holds ready low for exactly `WAIT_LIMIT`-1 cycles and raises it in the final one. It then expects a normal delivered word, no error and the burst continuing. In a separate burst it withholds ready for one more cycle and expects the error pulse, no response and an idle controller. A second overlap, a new request arriving while a burst is running, is provoked in the middle of a burst. The bench judges it by the absence of a strobe and an unchanged word order.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  // Strobes issued by the control FSM to the datapath each cycle.
  typedef struct packed {
    logic load;      // accept a new request
    logic eligible;  // accepted cycle may burst
    logic hyper;     // accepted cycle is a hyperpage burst
    logic take;      // ready accepted for the current beat
    logic last;      // this take finishes the bus cycle
    logic abort;     // wait limit reached without ready
    logic waitInc;   // beat still waiting
  } bhcStrobe_t;

endpackage

// File: rtl/bhc_ctrl.sv
module bhc_ctrl
  import bhc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBurstOk,
  input  logic       cfgBurstEn,
  input  logic       cfgHyperEn,
  input  logic       busBurstAck,
  input  logic       busReady,
  input  logic       firstBeat,
  input  logic       lastBeat,
  input  logic       waitExpired,
  output bhcStrobe_t strb,
  output logic       busy,
  output logic       busHyper
);

  logic inXfer;
  logic burstMode;
  logic hyperMode;
  logic goOn;

  always_comb begin
    strb          = '0;
    strb.eligible = cfgBurstEn & reqBurstOk;
    strb.hyper    = cfgBurstEn & reqBurstOk & cfgHyperEn;
    strb.load     = ~inXfer & reqValid;
    strb.take     = inXfer & busReady;
    strb.waitInc  = inXfer & ~busReady;
    strb.abort    = inXfer & ~busReady & waitExpired;
    // acknowledge only matters when the first word closes
    goOn          = hyperMode | (burstMode & busBurstAck);
    strb.last     = strb.take & (lastBeat | (firstBeat & ~goOn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inXfer    <= 1'b0;
      burstMode <= 1'b0;
      hyperMode <= 1'b0;
    end else if (strb.load) begin
      inXfer    <= 1'b1;
      burstMode <= strb.eligible;
      hyperMode <= strb.hyper;
    end else if (strb.last || strb.abort) begin
      inXfer    <= 1'b0;
      burstMode <= 1'b0;
      hyperMode <= 1'b0;
    end
  end

  assign busy     = inXfer;
  assign busHyper = inXfer & hyperMode;

endmodule

// File: rtl/bhc_dp.sv
module bhc_dp
  import bhc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEATS      = 4,
  parameter int WAIT_LIMIT = 8,
  localparam int IDX_W     = $clog2(BEATS),
  localparam int WAIT_W    = $clog2(WAIT_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bhcStrobe_t        strb,
  input  logic [IDX_W-1:0]  reqWord,
  input  logic [DATA_W-1:0] busData,
  output logic              busAs,
  output logic              busBurstReq,
  output logic [IDX_W-1:0]  busWord,
  output logic              firstBeat,
  output logic              lastBeat,
  output logic              waitExpired,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [IDX_W-1:0]  rspIdx,
  output logic              rspLast,
  output logic              rspErr
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BEATS - 1);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(WAIT_LIMIT - 1);

  logic [IDX_W-1:0]  startWord;
  logic [IDX_W-1:0]  beat;
  logic [WAIT_W-1:0] waitCnt;

  // interleaved order: each beat flips the start word by the beat number
  assign busWord     = startWord ^ beat;
  assign firstBeat   = (beat == '0);
  assign lastBeat    = (beat == LAST_IDX);
  assign waitExpired = (waitCnt == WAIT_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startWord   <= '0;
      beat        <= '0;
      waitCnt     <= '0;
      busAs       <= 1'b0;
      busBurstReq <= 1'b0;
    end else begin
      busAs       <= strb.load;
      busBurstReq <= strb.load & strb.eligible;
      if (strb.load) begin
        startWord <= strb.hyper ? '0 : reqWord;
        beat      <= '0;
        waitCnt   <= '0;
      end else if (strb.take) begin
        beat    <= beat + IDX_W'(1);
        waitCnt <= '0;
      end else if (strb.waitInc && !waitExpired) begin
        waitCnt <= waitCnt + WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspIdx   <= '0;
      rspLast  <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= strb.take;
      rspLast  <= strb.last;
      rspErr   <= strb.abort;
      if (strb.take) begin
        rspData <= busData;
        rspIdx  <= busWord;
      end
    end
  end

endmodule

// File: rtl/burst_handshake_ctrl.sv
module burst_handshake_ctrl
  import bhc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEATS      = 4,
  parameter int WAIT_LIMIT = 8,
  localparam int IDX_W     = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqWord,
  input  logic              reqBurstOk,
  input  logic              cfgBurstEn,
  input  logic              cfgHyperEn,
  output logic              busy,
  output logic              busAs,
  output logic              busBurstReq,
  output logic              busHyper,
  output logic [IDX_W-1:0]  busWord,
  input  logic              busBurstAck,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [IDX_W-1:0]  rspIdx,
  output logic              rspLast,
  output logic              rspErr
);

  bhcStrobe_t strb;
  logic       firstBeat;
  logic       lastBeat;
  logic       waitExpired;

  bhc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqBurstOk  (reqBurstOk),
    .cfgBurstEn  (cfgBurstEn),
    .cfgHyperEn  (cfgHyperEn),
    .busBurstAck (busBurstAck),
    .busReady    (busReady),
    .firstBeat   (firstBeat),
    .lastBeat    (lastBeat),
    .waitExpired (waitExpired),
    .strb        (strb),
    .busy        (busy),
    .busHyper    (busHyper)
  );

  bhc_dp #(
    .DATA_W     (DATA_W),
    .BEATS      (BEATS),
    .WAIT_LIMIT (WAIT_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWord     (reqWord),
    .busData     (busData),
    .busAs       (busAs),
    .busBurstReq (busBurstReq),
    .busWord     (busWord),
    .firstBeat   (firstBeat),
    .lastBeat    (lastBeat),
    .waitExpired (waitExpired),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .rspIdx      (rspIdx),
    .rspLast     (rspLast),
    .rspErr      (rspErr)
  );

endmodule

// File: rtl/bhc_checker.sv
module bhc_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             busAs,
  input logic             busBurstReq,
  input logic             busHyper,
  input logic [IDX_W-1:0] busWord,
  input logic             busReady,
  input logic             rspValid,
  input logic             rspLast,
  input logic             rspErr
);

  AST_AS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busAs |=> !busAs);  // R2

  AST_BREQ_WITH_AS: assert property (@(posedge clk) disable iff (!rstN)
    busBurstReq |-> busAs);  // R3

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !busReady) |=> (!busy || $stable(busWord)));  // R5

  AST_RSP_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busReady && busy));  // R6

  AST_LAST_IS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> rspValid);  // R6

  AST_HYPER_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    busHyper |-> busy);  // R7

  AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (!rspValid && !busy));  // R9

  AST_AS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busAs |-> busy);  // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLast) |-> !busy);  // R10

endmodule

bind burst_handshake_ctrl bhc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .busAs       (busAs),
  .busBurstReq (busBurstReq),
  .busHyper    (busHyper),
  .busWord     (busWord),
  .busReady    (busReady),
  .rspValid    (rspValid),
  .rspLast     (rspLast),
  .rspErr      (rspErr)
);

// File: tb/sim_burst_handshake_ctrl.sv
module sim_burst_handshake_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DATA_W     = 32;
  localparam int WAIT_LIMIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqWord = 2'd0;
  logic        reqBurstOk = 1'b0;
  logic        cfgBurstEn = 1'b0;
  logic        cfgHyperEn = 1'b0;
  logic        busy, busAs, busBurstReq, busHyper;
  logic [1:0]  busWord;
  logic        busBurstAck = 1'b0;
  logic        busReady = 1'b0;
  logic [31:0] busData = 32'd0;
  logic        rspValid, rspLast, rspErr;
  logic [31:0] rspData;
  logic [1:0]  rspIdx;

  int total = 0;
  int fails = 0;
  int seed  = 1;
  bit done  = 0;

  always #2.5 clk = ~clk;

  burst_handshake_ctrl #(.DATA_W(DATA_W), .BEATS(4), .WAIT_LIMIT(WAIT_LIMIT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .reqBurstOk(reqBurstOk), .cfgBurstEn(cfgBurstEn), .cfgHyperEn(cfgHyperEn),
    .busy(busy), .busAs(busAs), .busBurstReq(busBurstReq), .busHyper(busHyper),
    .busWord(busWord), .busBurstAck(busBurstAck), .busReady(busReady),
    .busData(busData), .rspValid(rspValid), .rspData(rspData), .rspIdx(rspIdx),
    .rspLast(rspLast), .rspErr(rspErr)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Start a bus cycle from an idle negedge; ends in the first transfer cycle.
  task automatic startReq(input logic [1:0] w, input logic en, input logic ok,
                          input logic hyp, input logic expBreq, input logic expHyp,
                          input string tag);
    cfgBurstEn = en; cfgHyperEn = hyp; reqBurstOk = ok; reqWord = w;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R2 busAs"}, 32'(busAs), 32'd1);
    check({tag, " R3 busBurstReq"}, 32'(busBurstReq), 32'(expBreq));
    check({tag, " R10 busy"}, 32'(busy), 32'd1);
    check({tag, " R7 busHyper"}, 32'(busHyper), 32'(expHyp));
  endtask

  // One beat: wait, present ready, check the delivered word.
  task automatic doBeat(input int delay, input logic ack, input logic [1:0] expW,
                        input logic expLast, input string tag);
    logic [31:0] d;
    repeat (delay) @(negedge clk);
    check({tag, " R5 busWord"}, 32'(busWord), 32'(expW));
    seed++;
    d = 32'hA500_0000 + 32'(seed * 977);
    busReady = 1'b1; busBurstAck = ack; busData = d;
    @(negedge clk);
    busReady = 1'b0; busBurstAck = 1'b0; busData = 32'd0;
    check({tag, " R6 rspValid"}, 32'(rspValid), 32'd1);
    check({tag, " R6 rspData"}, rspData, d);
    check({tag, " R6 rspIdx"}, 32'(rspIdx), 32'(expW));
    check({tag, " R6 rspLast"}, 32'(rspLast), 32'(expLast));
    check({tag, " R9 rspErr"}, 32'(rspErr), 32'd0);
    if (expLast) check({tag, " R10 busy after last"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 busAs", 32'(busAs), 32'd0);
    check("R1 busBurstReq", 32'(busBurstReq), 32'd0);
    check("R1 busHyper", 32'(busHyper), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid", 32'(rspValid), 32'd0);
    check("R1 rspErr", 32'(rspErr), 32'd0);
    check("R1 busy after release", 32'(busy), 32'd0);
  endtask

  // Full four-word burst from a given start word, R4/R5
  task automatic t_burst(input logic [1:0] s, input bit interrupt);
    string tag = $sformatf("burst s=%0d", s);
    startReq(s, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, tag);
    doBeat(int'(s), 1'b1, s ^ 2'd0, 1'b0, tag);
    if (interrupt) begin
      // R2: a request while busy is ignored
      reqWord = ~s; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check({tag, " R2 no busAs while busy"}, 32'(busAs), 32'd0);
    end
    doBeat(0, 1'b0, s ^ 2'd1, 1'b0, tag);
    doBeat(2, 1'b1, s ^ 2'd2, 1'b0, tag);
    doBeat(1, 1'b0, s ^ 2'd3, 1'b1, tag);
  endtask

  task automatic t_single_cases;
    // R3/R4: burst disabled, ack ignored
    startReq(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "noBurstEn");
    doBeat(1, 1'b1, 2'd2, 1'b1, "noBurstEn R4");
    // R3/R4: cycle not eligible
    startReq(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "notOk");
    doBeat(0, 1'b1, 2'd1, 1'b1, "notOk R4");
    // R4: request raised but no acknowledge
    startReq(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "noAck");
    doBeat(2, 1'b0, 2'd3, 1'b1, "noAck R4");
  endtask

  task automatic t_hyper;
    // R7: controller-generated order, acknowledge not needed
    startReq(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "hyper");
    for (int k = 0; k < 4; k++) begin
      if (k == 2) check("hyper R7 busHyper held", 32'(busHyper), 32'd1);
      doBeat(k % 2, 1'b0, 2'(k), k == 3, "hyper R7");
    end
    check("hyper R7 busHyper after", 32'(busHyper), 32'd0);
    // R8: hyperpage set but burst enable clear
    startReq(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "hyperNoBurst R8");
    doBeat(0, 1'b1, 2'd2, 1'b1, "hyperNoBurst R8");
  endtask

  task automatic t_wait_edge;
    // R9: ready in the last allowed wait cycle is accepted
    startReq(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "edge");
    doBeat(0, 1'b1, 2'd1, 1'b0, "edge");
    doBeat(WAIT_LIMIT - 1, 1'b0, 2'd0, 1'b0, "edge R9 last cycle");
    doBeat(WAIT_LIMIT - 1, 1'b0, 2'd3, 1'b0, "edge R9 last cycle");
    doBeat(0, 1'b0, 2'd2, 1'b1, "edge");
  endtask

  task automatic t_timeout;
    startReq(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "timeout");
    doBeat(0, 1'b1, 2'd2, 1'b0, "timeout");
    repeat (WAIT_LIMIT - 1) @(negedge clk);
    check("timeout R9 still busy", 32'(busy), 32'd1);
    check("timeout R9 no early err", 32'(rspErr), 32'd0);
    @(negedge clk);
    check("timeout R9 rspErr", 32'(rspErr), 32'd1);
    check("timeout R9 no rspValid", 32'(rspValid), 32'd0);
    check("timeout R10 idle", 32'(busy), 32'd0);
    @(negedge clk);
    check("timeout R9 err one cycle", 32'(rspErr), 32'd0);
    // R10: a fresh request is accepted after the abort
    startReq(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "afterAbort R10");
    doBeat(0, 1'b0, 2'd0, 1'b1, "afterAbort R10");
  endtask

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) t_burst(2'(s), s == 1);
    t_single_cases();
    t_hyper();
    t_wait_edge();
    t_timeout();
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule